// File: doc/BRIEF.md
# Paired Register File with Wide ALU

This block is the data path of a small 8-bit controller core. It holds sixteen 8-bit registers in two banks: even-numbered registers carry the low byte of a 16-bit pair and odd-numbered registers carry the high byte. A steering layer in front of the banks lets one operation read or write a single byte or a whole pair. The ALU alongside performs the usual byte operations. It also performs an unsigned 8x8 multiply that fills a pair, and four 16-bit add/subtract forms on pairs, with or without carry (borrow) in.

Each cycle in which `op_valid` is high, the block executes one operation from `op_code`, `idx_a`, `idx_b` and `imm_data`. The registers, the carry flag and the zero flag all update at that clock edge. A combinational read port (`rd_idx`/`rd_data`) exposes any register. Fetch, decode from program memory, stack and I/O are handled elsewhere.

Top module: `pairalu_core`

## Requirements
- R1: After reset all sixteen registers read 0x00, and both `carry_flag` and `zero_flag` are 0.
- R2: Opcode 0x0 (load) writes `imm_data` into register `idx_a`, and opcode 0x1 (move) copies register `idx_b` into register `idx_a`. Neither changes carry or zero.
- R3: A byte operation (opcodes 0x0 to 0x6) writes only register `idx_a`: an even index goes to the low bank and an odd index to the high bank. The other register of that pair keeps its value.
- R4: Opcode 0x2 (byte add) sets carry to bit 8 of the sum, and opcode 0x3 (byte subtract) sets carry when r[a] < r[b]. Opcodes 0x4/0x5/0x6 (and/or/xor) clear carry. All byte operations set zero when the 8-bit result is 0.
- R5: Opcode 0x8 multiplies r[a] by r[b] (unsigned) and writes the 16-bit product to the pair of `idx_a`, low byte in the even register and high byte in the odd one (0xca * 0xfe gives 0xc86c). Carry is cleared and zero reflects the product.
- R6: Opcode 0x9 adds pair(b) to pair(a) and opcode 0xA also adds the carry flag. The result goes to pair(a) and carry takes bit 16 (0xbeef + 0xcafe gives 0x89ed with carry 1).
- R7: Opcode 0xB computes pair(a) - pair(b) and opcode 0xC also subtracts the carry flag. The result goes to pair(a), and carry (as borrow) is set when pair(a) < pair(b) + borrow-in.
- R8: A pair operand named by an odd index uses the pair holding that register, {r[i|1], r[i&~1]}.
- R9: After any pair-writing operation, zero is set exactly when all 16 result bits are 0.
- R10: With `op_valid` low, or with an undefined opcode (0x7, 0xD, 0xE, 0xF), no register and no flag changes.
- R11: Operands are the register values before the edge, even when source and destination pairs are the same. The new values appear on `rd_data` right after the edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Execute the presented operation this cycle |
| op_code | input | 4 | Operation code |
| idx_a | input | 4 | First operand and destination register index |
| idx_b | input | 4 | Second operand register index |
| imm_data | input | 8 | Immediate byte for load |
| rd_idx | input | 4 | Read port register index |
| rd_data | output | 8 | Read port data (combinational) |
| carry_flag | output | 1 | Carry / borrow flag |
| zero_flag | output | 1 | Zero flag |

## Verification
Within one cycle a pair operation can read the same pair it overwrites while also using the carry flag as input and replacing it. Both happen in, for example, a subtract-with-borrow of a pair from itself. Directed cases provoke this (doubling a pair, subtracting a pair from itself with borrow set), and random operations drawn over all indices provoke it too. Every result is compared with a bench model computed only from the state before the edge, so a design that mixes old and new values shows up as a wrong register or flag.

// File: rtl/pairalu_pkg.sv
package pairalu_pkg;

   typedef enum logic [3:0] {
      OP_LOAD  = 4'h0,
      OP_MOVE  = 4'h1,
      OP_ADD   = 4'h2,
      OP_SUB   = 4'h3,
      OP_AND   = 4'h4,
      OP_OR    = 4'h5,
      OP_XOR   = 4'h6,
      OP_MUL   = 4'h8,
      OP_ADDW  = 4'h9,
      OP_ADDWC = 4'hA,
      OP_SUBW  = 4'hB,
      OP_SUBWC = 4'hC
   } op_e;

   typedef enum logic [1:0] {
      WR_NONE = 2'd0,
      WR_BYTE = 2'd1,
      WR_PAIR = 2'd2
   } wr_kind_e;

endpackage

// File: rtl/pairalu_bank.sv
module pairalu_bank #(
   parameter int W     = 8,
   parameter int DEPTH = 8,
   parameter int AW    = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic [AW-1:0] wr_addr,
   input  logic [W-1:0]  wr_data,
   input  logic [AW-1:0] ra_addr,
   output logic [W-1:0]  ra_data,
   input  logic [AW-1:0] rb_addr,
   output logic [W-1:0]  rb_data,
   input  logic [AW-1:0] rc_addr,
   output logic [W-1:0]  rc_data
);

   logic [W-1:0] mem [DEPTH];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      end else if (wr_en) begin
         mem[wr_addr] <= wr_data;
      end
   end

   assign ra_data = mem[ra_addr];
   assign rb_data = mem[rb_addr];
   assign rc_data = mem[rc_addr];

   AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> mem[$past(wr_addr)] == $past(wr_data)); // R2

endmodule

// File: rtl/pairalu_exec.sv
module pairalu_exec
   import pairalu_pkg::*;
#(
   parameter int W  = 8,
   parameter int WW = 2 * W
) (
   input  logic          op_valid,
   input  logic [3:0]    op_code,
   input  logic [W-1:0]  byte_a,
   input  logic [W-1:0]  byte_b,
   input  logic [WW-1:0] pair_a,
   input  logic [WW-1:0] pair_b,
   input  logic [W-1:0]  imm,
   input  logic          carry_in,
   output logic [WW-1:0] result,
   output wr_kind_e      wr_kind,
   output logic          flag_we,
   output logic          carry_nx,
   output logic          zero_nx
);

   logic [W:0]    sum8, dif8;
   logic [WW:0]   sumw, difw;
   logic [WW-1:0] prod;
   logic          cin_use;

   always_comb begin
      cin_use = (op_code == OP_ADDWC || op_code == OP_SUBWC) ? carry_in : 1'b0;
      sum8    = {1'b0, byte_a} + {1'b0, byte_b};
      dif8    = {1'b0, byte_a} - {1'b0, byte_b};
      sumw    = {1'b0, pair_a} + {1'b0, pair_b} + (WW+1)'(cin_use);
      difw    = {1'b0, pair_a} - {1'b0, pair_b} - (WW+1)'(cin_use);
      prod    = WW'(byte_a) * WW'(byte_b);
   end

   always_comb begin
      result   = '0;
      wr_kind  = WR_NONE;
      flag_we  = 1'b0;
      carry_nx = carry_in;
      if (op_valid) begin
         case (op_code)
            OP_LOAD: begin result = WW'(imm);    wr_kind = WR_BYTE; end
            OP_MOVE: begin result = WW'(byte_b); wr_kind = WR_BYTE; end
            OP_ADD: begin
               result = WW'(sum8[W-1:0]); wr_kind = WR_BYTE;
               flag_we = 1'b1; carry_nx = sum8[W];
            end
            OP_SUB: begin
               result = WW'(dif8[W-1:0]); wr_kind = WR_BYTE;
               flag_we = 1'b1; carry_nx = dif8[W];
            end
            OP_AND: begin
               result = WW'(byte_a & byte_b); wr_kind = WR_BYTE;
               flag_we = 1'b1; carry_nx = 1'b0;
            end
            OP_OR: begin
               result = WW'(byte_a | byte_b); wr_kind = WR_BYTE;
               flag_we = 1'b1; carry_nx = 1'b0;
            end
            OP_XOR: begin
               result = WW'(byte_a ^ byte_b); wr_kind = WR_BYTE;
               flag_we = 1'b1; carry_nx = 1'b0;
            end
            OP_MUL: begin
               result = prod; wr_kind = WR_PAIR;
               flag_we = 1'b1; carry_nx = 1'b0;
            end
            OP_ADDW, OP_ADDWC: begin
               result = sumw[WW-1:0]; wr_kind = WR_PAIR;
               flag_we = 1'b1; carry_nx = sumw[WW];
            end
            OP_SUBW, OP_SUBWC: begin
               result = difw[WW-1:0]; wr_kind = WR_PAIR;
               flag_we = 1'b1; carry_nx = difw[WW];
            end
            default: ;
         endcase
      end
      zero_nx = (wr_kind == WR_PAIR) ? (result == '0) : (result[W-1:0] == '0);
   end

endmodule

// File: rtl/pairalu_core.sv
module pairalu_core
   import pairalu_pkg::*;
#(
   parameter int DATA_W   = 8,
   parameter int NUM_REGS = 16,
   parameter int IDX_W    = $clog2(NUM_REGS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              op_valid,
   input  logic [3:0]        op_code,
   input  logic [IDX_W-1:0]  idx_a,
   input  logic [IDX_W-1:0]  idx_b,
   input  logic [DATA_W-1:0] imm_data,
   input  logic [IDX_W-1:0]  rd_idx,
   output logic [DATA_W-1:0] rd_data,
   output logic              carry_flag,
   output logic              zero_flag
);

   localparam int WW    = 2 * DATA_W;
   localparam int DEPTH = NUM_REGS / 2;
   localparam int AW    = IDX_W - 1;

   if (NUM_REGS < 4 || (NUM_REGS & (NUM_REGS - 1)) != 0) begin : g_bad_regs
      $error("pairalu_core: NUM_REGS must be a power of two of at least 4");
   end
   if (DATA_W < 2) begin : g_bad_width
      $error("pairalu_core: DATA_W must be at least 2");
   end

   logic [DATA_W-1:0] bank_ra [2];
   logic [DATA_W-1:0] bank_rb [2];
   logic [DATA_W-1:0] bank_rc [2];
   logic [DATA_W-1:0] bank_wd [2];
   logic              bank_we [2];

   logic [WW-1:0]     pair_a, pair_b, result;
   logic [DATA_W-1:0] byte_a, byte_b;
   wr_kind_e          wr_kind;
   logic              flag_we, carry_nx, zero_nx;

   // bank 0 holds even (low) registers, bank 1 holds odd (high) registers
   for (genvar g = 0; g < 2; g++) begin : g_bank
      pairalu_bank #(.W(DATA_W), .DEPTH(DEPTH), .AW(AW)) u_bank (
         .clk     (clk),
         .rst_n   (rst_n),
         .wr_en   (bank_we[g]),
         .wr_addr (idx_a[IDX_W-1:1]),
         .wr_data (bank_wd[g]),
         .ra_addr (idx_a[IDX_W-1:1]),
         .ra_data (bank_ra[g]),
         .rb_addr (idx_b[IDX_W-1:1]),
         .rb_data (bank_rb[g]),
         .rc_addr (rd_idx[IDX_W-1:1]),
         .rc_data (bank_rc[g])
      );
      assign bank_we[g] = (wr_kind == WR_PAIR) ||
                          (wr_kind == WR_BYTE && idx_a[0] == 1'(g));
   end

   assign pair_a  = {bank_ra[1], bank_ra[0]};
   assign pair_b  = {bank_rb[1], bank_rb[0]};
   assign byte_a  = idx_a[0]  ? bank_ra[1] : bank_ra[0];
   assign byte_b  = idx_b[0]  ? bank_rb[1] : bank_rb[0];
   assign rd_data = rd_idx[0] ? bank_rc[1] : bank_rc[0];

   assign bank_wd[0] = result[DATA_W-1:0];
   assign bank_wd[1] = (wr_kind == WR_PAIR) ? result[WW-1:DATA_W] : result[DATA_W-1:0];

   pairalu_exec #(.W(DATA_W), .WW(WW)) u_exec (
      .op_valid (op_valid),
      .op_code  (op_code),
      .byte_a   (byte_a),
      .byte_b   (byte_b),
      .pair_a   (pair_a),
      .pair_b   (pair_b),
      .imm      (imm_data),
      .carry_in (carry_flag),
      .result   (result),
      .wr_kind  (wr_kind),
      .flag_we  (flag_we),
      .carry_nx (carry_nx),
      .zero_nx  (zero_nx)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         carry_flag <= 1'b0;
         zero_flag  <= 1'b0;
      end else if (flag_we) begin
         carry_flag <= carry_nx;
         zero_flag  <= zero_nx;
      end
   end

   AST_ONE_BANK: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && op_code < 4'h7) |-> $onehot0({bank_we[1], bank_we[0]})); // R3

   AST_MUL_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && op_code == OP_MUL) |=> !carry_flag); // R5

   AST_IDLE_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
      !op_valid |=> ($stable(carry_flag) && $stable(zero_flag))); // R10

   AST_MOVE_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && (op_code == OP_LOAD || op_code == OP_MOVE))
      |=> ($stable(carry_flag) && $stable(zero_flag))); // R2

endmodule

// File: tb/pairalu_core_bench.sv
module pairalu_core_bench;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       op_valid = 1'b0;
   logic [3:0] op_code = '0;
   logic [3:0] idx_a = '0;
   logic [3:0] idx_b = '0;
   logic [7:0] imm_data = '0;
   logic [3:0] rd_idx = '0;
   logic [7:0] rd_data;
   logic       carry_flag, zero_flag;

   int unsigned n_checks = 0;
   int unsigned n_fails  = 0;
   bit          done = 1'b0;

   logic [7:0] exp_reg [16];
   logic       exp_c = 1'b0;
   logic       exp_z = 1'b0;

   pairalu_core u_pairalu_core (
      .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
      .idx_a(idx_a), .idx_b(idx_b), .imm_data(imm_data), .rd_idx(rd_idx),
      .rd_data(rd_data), .carry_flag(carry_flag), .zero_flag(zero_flag)
   );

   always #10 clk = ~clk;

   task automatic chk(input bit ok, input string tag, input int act, input int exp_v);
      n_checks++;
      if (!ok) begin
         n_fails++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp_v);
      end
   endtask

   task automatic model_step(input logic [3:0] op, input logic [3:0] a,
                             input logic [3:0] b, input logic [7:0] imm);
      int unsigned va, vb, wa, wb, t, cin;
      int pa;
      va  = exp_reg[a];
      vb  = exp_reg[b];
      pa  = int'(a) & 14;
      wa  = {exp_reg[a | 4'd1], exp_reg[a & 4'd14]};
      wb  = {exp_reg[b | 4'd1], exp_reg[b & 4'd14]};
      cin = (op == 4'hA || op == 4'hC) ? int'(exp_c) : 0;
      case (op)
         4'h0: exp_reg[a] = imm;
         4'h1: exp_reg[a] = vb[7:0];
         4'h2: begin t = va + vb; exp_reg[a] = t[7:0]; exp_c = t[8]; exp_z = (t[7:0] == 0); end
         4'h3: begin t = va - vb; exp_reg[a] = t[7:0]; exp_c = (va < vb); exp_z = (t[7:0] == 0); end
         4'h4: begin t = va & vb; exp_reg[a] = t[7:0]; exp_c = 0; exp_z = (t[7:0] == 0); end
         4'h5: begin t = va | vb; exp_reg[a] = t[7:0]; exp_c = 0; exp_z = (t[7:0] == 0); end
         4'h6: begin t = va ^ vb; exp_reg[a] = t[7:0]; exp_c = 0; exp_z = (t[7:0] == 0); end
         4'h8: begin
            t = va * vb; exp_reg[pa] = t[7:0]; exp_reg[pa+1] = t[15:8];
            exp_c = 0; exp_z = (t[15:0] == 0);
         end
         4'h9, 4'hA: begin
            t = wa + wb + cin; exp_reg[pa] = t[7:0]; exp_reg[pa+1] = t[15:8];
            exp_c = t[16]; exp_z = (t[15:0] == 0);
         end
         4'hB, 4'hC: begin
            t = wa - wb - cin; exp_reg[pa] = t[7:0]; exp_reg[pa+1] = t[15:8];
            exp_c = (wa < wb + cin); exp_z = (t[15:0] == 0);
         end
         default: ;
      endcase
   endtask

   task automatic issue(input logic v, input logic [3:0] op, input logic [3:0] a,
                        input logic [3:0] b, input logic [7:0] imm);
      @(negedge clk);
      op_valid = v; op_code = op; idx_a = a; idx_b = b; imm_data = imm;
      @(posedge clk);
      #1;
      op_valid = 1'b0;
      if (v) model_step(op, a, b, imm);
   endtask

   task automatic read_reg(input logic [3:0] r, output logic [7:0] val);
      rd_idx = r;
      #1;
      val = rd_data;
   endtask

   task automatic check_all(input string tag);
      logic [7:0] v;
      bit ok = 1'b1;
      int bad = -1;
      for (int r = 0; r < 16; r++) begin
         read_reg(4'(r), v);
         if (v !== exp_reg[r] && ok) begin ok = 1'b0; bad = r; end
      end
      if (!ok) begin
         read_reg(4'(bad), v);
         chk(1'b0, $sformatf("%s reg r%0d", tag, bad), int'(v), int'(exp_reg[bad]));
      end else begin
         chk(1'b1, tag, 0, 0);
      end
      chk(carry_flag === exp_c, {tag, " carry"}, int'(carry_flag), int'(exp_c));
      chk(zero_flag === exp_z, {tag, " zero"}, int'(zero_flag), int'(exp_z));
   endtask

   task automatic chk_reg(input logic [3:0] r, input logic [7:0] e, input string tag);
      logic [7:0] v;
      read_reg(r, v);
      chk(v === e, tag, int'(v), int'(e));
   endtask

   initial begin
      logic [3:0] op_list [13] = '{4'h0, 4'h1, 4'h2, 4'h3, 4'h4, 4'h5, 4'h6,
                                   4'h8, 4'h9, 4'hA, 4'hB, 4'hC, 4'hF};
      void'($urandom(32'd20260));
      for (int r = 0; r < 16; r++) exp_reg[r] = 8'h00;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      check_all("R1 reset state");

      // R4 / R3: byte add overflows, partner untouched
      issue(1, 4'h0, 4'd5, 4'd0, 8'hff);
      issue(1, 4'h0, 4'd6, 4'd0, 8'h01);
      issue(1, 4'h2, 4'd5, 4'd6, 8'h00);
      chk(carry_flag === 1'b1, "R4 byte add carry", int'(carry_flag), 1);
      chk(zero_flag === 1'b1, "R4 byte add zero", int'(zero_flag), 1);
      chk_reg(4'd4, 8'h00, "R3 partner of r5 unchanged");
      check_all("R3 R4 byte add");

      // R5 multiply example; carry set before and cleared after
      issue(1, 4'h0, 4'd0, 4'd0, 8'hca);
      issue(1, 4'h0, 4'd2, 4'd0, 8'hfe);
      issue(1, 4'h8, 4'd0, 4'd2, 8'h00);
      chk_reg(4'd0, 8'h6c, "R5 product low byte");
      chk_reg(4'd1, 8'hc8, "R5 product high byte");
      chk(carry_flag === 1'b0, "R5 carry cleared", int'(carry_flag), 0);
      check_all("R5 multiply");

      // R2: load and move keep flags
      issue(1, 4'h3, 4'd6, 4'd2, 8'h00);
      issue(1, 4'h1, 4'd9, 4'd2, 8'h00);
      issue(1, 4'h0, 4'd8, 4'd0, 8'h00);
      check_all("R2 move/load keep flags");

      // R6 wide add example
      issue(1, 4'h0, 4'd1, 4'd0, 8'hca);
      issue(1, 4'h0, 4'd0, 4'd0, 8'hfe);
      issue(1, 4'h0, 4'd3, 4'd0, 8'hbe);
      issue(1, 4'h0, 4'd2, 4'd0, 8'hef);
      issue(1, 4'h9, 4'd2, 4'd0, 8'h00);
      chk_reg(4'd2, 8'hed, "R6 sum low");
      chk_reg(4'd3, 8'h89, "R6 sum high");
      chk(carry_flag === 1'b1, "R6 sum carry", int'(carry_flag), 1);
      issue(1, 4'hA, 4'd2, 4'd0, 8'h00);
      check_all("R6 add with carry-in");

      // R7 / R9 / R11: same pair as both operands, borrow in and out
      issue(1, 4'h0, 4'd4, 4'd0, 8'h34);
      issue(1, 4'h0, 4'd5, 4'd0, 8'h12);
      issue(1, 4'hB, 4'd4, 4'd5, 8'h00);
      chk(zero_flag === 1'b1, "R9 wide zero", int'(zero_flag), 1);
      chk(carry_flag === 1'b0, "R7 no borrow on equal", int'(carry_flag), 0);
      issue(1, 4'h0, 4'd4, 4'd0, 8'h00);
      issue(1, 4'h0, 4'd7, 4'd0, 8'h01);
      issue(1, 4'hB, 4'd4, 4'd6, 8'h00);
      chk(carry_flag === 1'b1, "R7 borrow out", int'(carry_flag), 1);
      issue(1, 4'hC, 4'd4, 4'd4, 8'h00);
      chk_reg(4'd4, 8'hff, "R11 self subtract with borrow low");
      chk_reg(4'd5, 8'hff, "R11 self subtract with borrow high");
      check_all("R7 R11 subtract with borrow");

      // R8: odd indices select the containing pair
      issue(1, 4'h9, 4'd7, 4'd3, 8'h00);
      issue(1, 4'h8, 4'd9, 4'd1, 8'h00);
      check_all("R8 odd index pairs");

      // R10: idle and undefined opcodes
      issue(0, 4'h8, 4'd0, 4'd2, 8'h00);
      issue(0, 4'h0, 4'd3, 4'd0, 8'h55);
      issue(1, 4'hF, 4'd2, 4'd2, 8'h77);
      issue(1, 4'h7, 4'd6, 4'd1, 8'h77);
      issue(1, 4'hD, 4'd0, 4'd0, 8'h77);
      check_all("R10 no effect");

      // R11 random mix, checked against the model
      for (int n = 0; n < 300; n++) begin
         issue(($urandom_range(9, 0) != 0), op_list[$urandom_range(12, 0)],
               4'($urandom_range(15, 0)), 4'($urandom_range(15, 0)),
               8'($urandom_range(255, 0)));
         if (n % 3 == 0) check_all($sformatf("R11 random op %0d", n));
      end
      check_all("R11 random final");

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_checks++;
         n_fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
         $finish;
      end
   end

endmodule